// File: doc/BRIEF.md
# Serial Receive Overrun Status Logic

This block sits between the bit-level receive shifter of a serial port and the software register bus. Every time the shifter finishes a frame it raises a one-cycle completion pulse together with the assembled byte. The block holds that byte in a data register and keeps two status flags: a buffer-full flag and an overrun flag. It applies the rules that set and clear these flags, lock out the receiver, and keep the older byte when a frame arrives too early.

Software reads the status and data through a small register bus. Reads are combinational and take effect in the same cycle. A flag can only be cleared by a deliberate read-then-write sequence: software first reads the status and sees the flag at 1, then writes 0 to that bit. While an overrun is pending, the block asserts a receive-inhibit output towards the shifter. In clocked synchronous mode it also asserts a transmit-inhibit output.

Top module: `rx_ovr_status`

## Requirements
- R1: When an accepted frame-complete pulse arrives while the full flag is 1, the overrun flag becomes 1 on the next clock edge.
- R2: Reset clears both flags, the data register and the armed state. A standby request clears the overrun flag and its armed state, and leaves the full flag as it was.
- R3: The status register is at address 0, with the full flag in bit 0 and the overrun flag in bit 1. The overrun flag clears only on a status write with bit 1 at 0 that follows a status read returning bit 1 as 1. Any status write disarms both flags. Writing 1 never sets a flag.
- R4: Driving receive-enable low does not change the overrun flag.
- R5: On an overrun, the data register (address 1) keeps the byte received before it, and the new byte is lost.
- R6: The receive-inhibit output equals the overrun flag. A completion pulse that arrives while receive-inhibit is 1 or receive-enable is 0 changes no flag and no data.
- R7: The transmit-inhibit output is 1 only when the overrun flag is 1 and the synchronous-mode input is 1.
- R8: An accepted frame that arrives while the full flag is 0 loads the data register and sets the full flag. The full flag clears through the same read-1-then-write-0 sequence, using bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_done | input | 1 | Frame-complete pulse from the shifter |
| rx_byte | input | DATA_W | Received byte, valid with rx_done |
| rx_en | input | 1 | Receive enable |
| standby | input | 1 | Standby request, clears the overrun flag |
| sync_mode | input | 1 | 1 = clocked synchronous, 0 = asynchronous |
| bus_addr | input | 1 | 0 = status, 1 = data |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe (status only) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational |
| rx_inhibit | output | 1 | Stops the receiver while an overrun is pending |
| tx_inhibit | output | 1 | Stops the transmitter in synchronous mode during an overrun |

## Verification
The hardest state to reach is a pending overrun whose bit is written 0 but which is not armed. Every status read that would show the flag also arms it. The bench therefore watches the overrun flag through the receive-inhibit output instead of reading the status register. Between a status read and the clearing write, it inserts a status write that does not clear, to show that the armed state does not carry over. It also sends frames while inhibited and while receive is disabled, then reads the data register to confirm that the byte is unchanged.

// File: rtl/rx_ovr_status.sv
module rx_ovr_status #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_done,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              rx_en,
  input  logic              standby,
  input  logic              sync_mode,
  input  logic              bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              rx_inhibit,
  output logic              tx_inhibit
);
  localparam int FULL_BIT = 0;
  localparam int OVR_BIT  = 1;

  logic              full_q, ovr_q, arm_full_q, arm_ovr_q;
  logic [DATA_W-1:0] data_q;
  logic              accept, stat_rd, stat_wr, clr_full, clr_ovr;
  logic [DATA_W-1:0] unused_wdata;

  assign unused_wdata = bus_wdata;
  assign accept   = rx_done & rx_en & ~ovr_q;
  assign stat_rd  = bus_rd & ~bus_addr;
  assign stat_wr  = bus_wr & ~bus_addr;
  assign clr_full = stat_wr & arm_full_q & ~bus_wdata[FULL_BIT];
  assign clr_ovr  = stat_wr & arm_ovr_q & ~bus_wdata[OVR_BIT];

  assign rx_inhibit = ovr_q;
  assign tx_inhibit = ovr_q & sync_mode;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr) bus_rdata = data_q;
    else begin
      bus_rdata[FULL_BIT] = full_q;
      bus_rdata[OVR_BIT]  = ovr_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (accept && !full_q) begin
      full_q <= 1'b1;
      data_q <= rx_byte;
    end else if (clr_full) begin
      full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || standby)      ovr_q <= 1'b0;
    else if (accept && full_q)  ovr_q <= 1'b1;
    else if (clr_ovr)           ovr_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arm_full_q <= 1'b0;
      arm_ovr_q  <= 1'b0;
    end else begin
      if (stat_wr)              arm_full_q <= 1'b0;
      else if (stat_rd && full_q) arm_full_q <= 1'b1;
      if (stat_wr || standby)   arm_ovr_q <= 1'b0;
      else if (stat_rd && ovr_q) arm_ovr_q <= 1'b1;
    end
  end

  p_ovr_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rx_en && !rx_inhibit && full_q && !standby) |=> ovr_q);
  p_standby_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> !ovr_q);
  p_no_unarmed_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !arm_ovr_q && !standby) |=> ovr_q);
  p_write_no_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovr_q && !(rx_done && full_q)) |=> !ovr_q);
  p_keep_old_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && full_q) |=> $stable(data_q));
  p_ignore_inhibit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((rx_inhibit || !rx_en) && !bus_wr && !standby) |=>
      ($stable(full_q) && $stable(ovr_q) && $stable(data_q)));
  always_comb if (rst_n && !sync_mode) p_tx_async_r7: assert (!tx_inhibit);
endmodule

// File: tb/rx_ovr_status_tb.sv
module rx_ovr_status_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_done = 0, rx_en = 0, standby = 0, sync_mode = 0;
  logic bus_addr = 0, bus_rd = 0, bus_wr = 0;
  logic [7:0] rx_byte = 0, bus_wdata = 0, bus_rdata;
  logic rx_inhibit, tx_inhibit;
  int checks = 0, fails = 0;
  logic [7:0] v;

  always #5 clk = ~clk;

  rx_ovr_status #(.DATA_W(8)) u_dut (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic frame(logic [7:0] b);
    @(negedge clk); rx_done = 1; rx_byte = b;
    @(negedge clk); rx_done = 0;
  endtask

  task automatic rd(logic a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic wr(logic [7:0] d);
    @(negedge clk); bus_addr = 0; bus_wr = 1; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic t_reset;
    rd(0, v); chk("R2 reset status", v, 8'h00);
    chk("R6 reset inhibit", {7'b0, rx_inhibit}, 8'h00);
  endtask

  task automatic t_overrun;
    frame(8'hA5);
    rd(1, v); chk("R8 data load", v, 8'hA5);
    frame(8'h3C);
    chk("R1 overrun set", {7'b0, rx_inhibit}, 8'h01);
    rd(1, v); chk("R5 old byte kept", v, 8'hA5);
    chk("R7 async no tx inhibit", {7'b0, tx_inhibit}, 8'h00);
    @(negedge clk); sync_mode = 1; #1;
    chk("R7 sync tx inhibit", {7'b0, tx_inhibit}, 8'h01);
    @(negedge clk); sync_mode = 0;
  endtask

  task automatic t_ignore;
    frame(8'h77);
    rd(1, v); chk("R6 inhibited frame ignored", v, 8'hA5);
    @(negedge clk); rx_en = 0;
    repeat (3) @(negedge clk);
    chk("R4 rx_en low keeps overrun", {7'b0, rx_inhibit}, 8'h01);
    rx_en = 1;
  endtask

  task automatic t_clear;
    wr(8'h00);
    chk("R3 unarmed write keeps overrun", {7'b0, rx_inhibit}, 8'h01);
    rd(0, v); chk("R3 status read", v, 8'h03);
    wr(8'h03);
    wr(8'h00);
    chk("R3 disarm after write", {7'b0, rx_inhibit}, 8'h01);
    rd(0, v);
    wr(8'h01);
    chk("R3 armed clear", {7'b0, rx_inhibit}, 8'h00);
    wr(8'h02);
    rd(0, v); chk("R3 write 1 no set", v, 8'h01);
    wr(8'h00);
    rd(0, v); chk("R8 full clear", v, 8'h00);
  endtask

  task automatic t_disabled;
    @(negedge clk); rx_en = 0;
    frame(8'h99);
    rd(0, v); chk("R6 disabled frame status", v, 8'h00);
    rd(1, v); chk("R6 disabled frame data", v, 8'hA5);
    rx_en = 1;
  endtask

  task automatic t_standby;
    frame(8'h5A);
    frame(8'h11);
    rd(0, v); chk("R1 second overrun", v, 8'h03);
    @(negedge clk); standby = 1;
    @(negedge clk); standby = 0;
    rd(0, v); chk("R2 standby clears overrun", v, 8'h01);
    rd(1, v); chk("R5 data after standby", v, 8'h5A);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; rx_en = 1;
    t_reset;
    t_overrun;
    t_ignore;
    t_clear;
    t_disabled;
    t_standby;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule